// File: doc/BRIEF.md
# Electronic Shutter Setting Interface

This block takes the electronic-shutter setting of an image-sensor timing generator and turns it into a per-line discharge request for the pulse generator downstream. The setting has two parts: a two-bit shutter mode and a speed code. It can arrive in one of two ways, chosen by a select input. In parallel entry, the speed pins and the two mode pins are sampled as plain levels. In serial entry, the same speed pins act as a three-wire port, carrying a strobe, a shift clock and a data line.

The captured setting waits in a pending register. It moves into the active register only when a field starts, so the exposure time never changes in the middle of a field. For each line-start pulse, the block decides from the active mode, the speed code and the line's index in the field whether the sensor substrate should be discharged on that line.

A separate trigger mode overrides the shutter mode. In that mode the sensor is cleared on every line until a rising edge on the trigger input starts the exposure. The next field start re-arms the clearing.

Top module: `shutter_setting_if`

## Requirements
- R1: After reset the active mode reads 2'b11 (no shutter), the active speed code reads all ones, and no discharge request is raised, which matches unconnected pins pulled high.
- R2: With serial_sel_i low, the word {mode_pins_i, spd_pins_i} is taken as the pending setting on every clock; mode_pins_i[1] is the upper mode bit.
- R3: With serial_sel_i high, spd_pins_i[0] is the strobe, spd_pins_i[1] the shift clock and spd_pins_i[2] the data. Each rising shift-clock edge seen while the strobe is low shifts one data bit in. The word is 5 bits, sent first bit first in the order mode[1], mode[0], speed[2], speed[1], speed[0]. A rising strobe edge latches the shifted word as pending. Shift-clock edges that occur while the strobe is high are ignored.
- R4: In mode 2'b01 (high speed), a discharge is requested for every line whose index since field start is at most the speed code.
- R5: In mode 2'b00 (flickerless), a discharge is requested for lines 0 to FLK_LAST_LINE (default 3), whatever the speed code.
- R6: In mode 2'b10 (low speed) and mode 2'b11 (no shutter), no discharge is requested.
- R7: The pending setting becomes visible on mode_o and speed_o only in the cycle after field_start_i; at no other time do mode_o and speed_o change.
- R8: With trig_mode_i high, a discharge is requested on every line while the block is armed. A rising edge on trig_i disarms it, and field_start_i re-arms it. In this mode the shutter mode has no effect.
- R9: disch_req_o goes high only in the cycle after a line_start_i pulse, and stays high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| serial_sel_i | input | 1 | 0: parallel entry, 1: serial entry |
| spd_pins_i | input | SPD_W | Speed bits, or strobe/clock/data in serial entry |
| mode_pins_i | input | 2 | Shutter mode bits (parallel entry) |
| trig_mode_i | input | 1 | 1: trigger-started shutter |
| trig_i | input | 1 | Exposure start trigger, rising edge |
| field_start_i | input | 1 | One-cycle field start pulse |
| line_start_i | input | 1 | One-cycle line start pulse |
| mode_o | output | 2 | Active shutter mode |
| speed_o | output | SPD_W | Active speed code |
| disch_req_o | output | 1 | Discharge request for the current line |

## Verification
A pin change in parallel entry reaches the pending register at the next edge. A strobe rise in serial entry latches on the edge where it is seen. In both cases mode_o and speed_o change at the edge that samples field_start_i. disch_req_o is registered, so it is due exactly one edge after line_start_i. The bench drives inputs on falling edges and samples after the edge that is due, checking every line of a 12-line field for all 32 parallel settings and all 32 serial words. It also reads mode_o before each field start, to confirm that a latched setting does not take effect early.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  typedef enum logic [1:0] {
    MODE_FLK  = 2'b00,
    MODE_FAST = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_OFF  = 2'b11
  } shut_mode_e;
endpackage

// File: rtl/shutter_entry.sv
module shutter_entry #(
  parameter int SPD_W  = 3,
  localparam int WORD_W = SPD_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              serial_sel_i,
  input  logic [SPD_W-1:0]  spd_pins_i,
  input  logic [1:0]        mode_pins_i,
  output logic [WORD_W-1:0] pending_o
);
  logic stb_q, sck_q;
  logic [WORD_W-1:0] shift_q;
  logic stb_rise, sck_rise;

  assign stb_rise = spd_pins_i[0] & ~stb_q;
  assign sck_rise = spd_pins_i[1] & ~sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q     <= 1'b1;
      sck_q     <= 1'b1;
      shift_q   <= '1;
      pending_o <= '1;
    end else begin
      stb_q <= spd_pins_i[0];
      sck_q <= spd_pins_i[1];
      if (!serial_sel_i) begin
        pending_o <= {mode_pins_i, spd_pins_i};
      end else begin
        if (sck_rise && !spd_pins_i[0]) shift_q <= {shift_q[WORD_W-2:0], spd_pins_i[2]};
        if (stb_rise) pending_o <= shift_q;
      end
    end
  end

  // R3: in serial entry pending moves only on a strobe rise
  a_r3_pending_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serial_sel_i && !stb_rise) |=> $stable(pending_o));
  // R3: shift register frozen while strobe is high
  a_r3_no_shift_stb_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spd_pins_i[0] && stb_q) |=> $stable(shift_q));
endmodule

// File: rtl/shutter_line_gen.sv
module shutter_line_gen
  import shutter_pkg::*;
#(
  parameter int SPD_W         = 3,
  parameter int LINE_W        = 10,
  parameter int FLK_LAST_LINE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             field_start_i,
  input  logic             line_start_i,
  input  logic             trig_mode_i,
  input  logic             trig_i,
  input  shut_mode_e       mode_i,
  input  logic [SPD_W-1:0] speed_i,
  output logic             disch_req_o
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;
  localparam logic [LINE_W-1:0] FLK_LIM = LINE_W'(FLK_LAST_LINE);

  logic [LINE_W-1:0] cnt_q;
  logic armed_q, trig_q, want;

  always_comb begin
    if (trig_mode_i) want = armed_q;
    else begin
      unique case (mode_i)
        MODE_FAST: want = (cnt_q <= LINE_W'(speed_i));
        MODE_FLK:  want = (cnt_q <= FLK_LIM);
        default:   want = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      armed_q     <= 1'b1;
      trig_q      <= 1'b0;
      disch_req_o <= 1'b0;
    end else begin
      trig_q      <= trig_i;
      disch_req_o <= line_start_i & want;
      if (field_start_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        if (line_start_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (trig_i && !trig_q) armed_q <= 1'b0;
      end
    end
  end

  // R9: request only right after a line start
  a_r9_req_after_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disch_req_o |-> $past(line_start_i));
  // R6: low speed and off never request
  a_r6_quiet_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !trig_mode_i && mode_i[1]) |=> !disch_req_o);
  // R4: high speed stops past the speed code
  a_r4_fast_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !trig_mode_i && mode_i == MODE_FAST && cnt_q > LINE_W'(speed_i)) |=> !disch_req_o);
  // R8: disarmed trigger mode is quiet
  a_r8_disarmed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && trig_mode_i && !armed_q) |=> !disch_req_o);
endmodule

// File: rtl/shutter_setting_if.sv
module shutter_setting_if
  import shutter_pkg::*;
#(
  parameter int SPD_W         = 3,
  parameter int LINE_W        = 10,
  parameter int FLK_LAST_LINE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             serial_sel_i,
  input  logic [SPD_W-1:0] spd_pins_i,
  input  logic [1:0]       mode_pins_i,
  input  logic             trig_mode_i,
  input  logic             trig_i,
  input  logic             field_start_i,
  input  logic             line_start_i,
  output logic [1:0]       mode_o,
  output logic [SPD_W-1:0] speed_o,
  output logic             disch_req_o
);
  localparam int WORD_W = SPD_W + 2;

  logic [WORD_W-1:0] pending;
  logic [WORD_W-1:0] active_q;

  shutter_entry #(.SPD_W(SPD_W)) entry_i (
    .clk_i, .rst_ni, .serial_sel_i, .spd_pins_i, .mode_pins_i,
    .pending_o(pending)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            active_q <= '1;
    else if (field_start_i) active_q <= pending;
  end

  assign mode_o  = active_q[WORD_W-1 -: 2];
  assign speed_o = active_q[SPD_W-1:0];

  shutter_line_gen #(.SPD_W(SPD_W), .LINE_W(LINE_W), .FLK_LAST_LINE(FLK_LAST_LINE)) line_i (
    .clk_i, .rst_ni, .field_start_i, .line_start_i, .trig_mode_i, .trig_i,
    .mode_i(shut_mode_e'(mode_o)), .speed_i(speed_o), .disch_req_o
  );

  // R7: setting changes only at field start
  a_r7_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_start_i |=> ($stable(mode_o) && $stable(speed_o)));
endmodule

// File: tb/shutter_setting_if_tb.sv
module shutter_setting_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SPD_W = 3;
  localparam int FLK_LAST = 3;
  localparam int LINES = 12;

  logic clk = 0, rst_ni = 0;
  logic serial_sel = 0, trig_mode = 0, trig = 0, fstart = 0, lstart = 0;
  logic [SPD_W-1:0] spd = '1;
  logic [1:0] mpin = 2'b11;
  logic [1:0] mode_o;
  logic [SPD_W-1:0] speed_o;
  logic req;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shutter_setting_if dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .serial_sel_i(serial_sel), .spd_pins_i(spd),
    .mode_pins_i(mpin), .trig_mode_i(trig_mode), .trig_i(trig),
    .field_start_i(fstart), .line_start_i(lstart),
    .mode_o(mode_o), .speed_o(speed_o), .disch_req_o(req)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic field();
    fstart = 1; step(1); fstart = 0; step(1);
  endtask

  task automatic line(output logic r);
    lstart = 1; @(posedge clk); @(negedge clk); lstart = 0;
    r = req;
    step(1);
    check("R9 single-cycle request", int'(req), 0);
  endtask

  function automatic int exp_req(int m, int s, int l);
    if (m == 1) return int'(l <= s);
    if (m == 0) return int'(l <= FLK_LAST);
    return 0;
  endfunction

  task automatic run_field(int m, int s, string tag);
    logic r;
    field();
    check({tag, " mode"}, int'(mode_o), m);
    check({tag, " speed"}, int'(speed_o), s);
    for (int l = 0; l < LINES; l++) begin
      line(r);
      check(m == 1 ? "R4 fast line" : m == 0 ? "R5 flickerless line" : "R6 quiet line",
            int'(r), exp_req(m, s, l));
    end
  endtask

  task automatic send_word(logic [SPD_W+1:0] w);
    spd[0] = 0; step(1);
    for (int i = SPD_W + 1; i >= 0; i--) begin
      spd[2] = w[i]; spd[1] = 0; step(1);
      spd[1] = 1; step(1);
    end
    spd[1] = 0; step(1);
    spd[0] = 1; step(2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int prev_m, prev_s;
    logic r;
    step(2);
    check("R1 reset mode", int'(mode_o), 3);
    check("R1 reset speed", int'(speed_o), 7);
    check("R1 reset req", int'(req), 0);
    rst_ni = 1; step(1);
    line(r);
    check("R1 no request after reset", int'(r), 0);

    // R2 parallel sweep
    prev_m = 3; prev_s = 7;
    for (int w = 0; w < 32; w++) begin
      mpin = 2'(w >> 3); spd = 3'(w);
      step(3);
      check("R7 no early change mode", int'(mode_o), prev_m);
      check("R7 no early change speed", int'(speed_o), prev_s);
      run_field(w >> 3, w & 7, "R2 parallel");
      prev_m = w >> 3; prev_s = w & 7;
    end

    // R3 serial sweep; parallel pins must be ignored
    serial_sel = 1; spd = '1; mpin = 2'b00; step(2);
    for (int w = 0; w < 32; w++) begin
      send_word(5'(w));
      mpin = 2'(~w >> 3);
      check("R7 serial no early change", int'(mode_o), prev_m);
      run_field(w >> 3, w & 7, "R3 serial");
      prev_m = w >> 3; prev_s = w & 7;
    end

    // R3 shifts with strobe high ignored
    send_word(5'b01010);
    for (int i = 0; i < 5; i++) begin
      spd[2] = 1; spd[1] = 0; step(1); spd[1] = 1; step(1);
    end
    spd[1] = 0; spd[0] = 0; step(1); spd[0] = 1; step(2);
    field();
    check("R3 strobe-high shift ignored mode", int'(mode_o), 1);
    check("R3 strobe-high shift ignored speed", int'(speed_o), 2);

    // R8 trigger mode with shutter off
    send_word(5'b11111); field();
    trig_mode = 1;
    for (int l = 0; l < 3; l++) begin line(r); check("R8 armed line", int'(r), 1); end
    trig = 1; step(1); trig = 0; step(1);
    for (int l = 0; l < 3; l++) begin line(r); check("R8 disarmed line", int'(r), 0); end
    field();
    line(r); check("R8 rearmed at field start", int'(r), 1);
    trig = 1; step(1); trig = 0; step(1);
    line(r); check("R8 second trigger disarms", int'(r), 0);
    trig_mode = 0;
    field();
    line(r); check("R6 off after trigger mode", int'(r), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule